// File: doc/BRIEF.md
# Segmented-Window Reseeding Pattern Controller

This block drives built-in self-test pattern generation for scan-based logic. A table of seeds is read one word at a time through a memory read port. Each seed is loaded into a linear feedback shift register. The register then runs freely and produces a window of test vectors. Each vector is shifted serially into the scan chains and followed by a single capture clock. Between two vectors of the same window the register is never reloaded.

Each window is split into `NUM_SEGS` segments of `SEG_VECS` vectors each. For every seed only the first k segments are applied; the remaining segments of that window are skipped, and the controller moves on to the next seed. The seed table is stored sorted by decreasing k. Because of this, a seed does not need to store its own k. Each seed word carries a single step bit that tells whether k stays the same or drops by one relative to the previous seed. A software-free start pulse begins a pass over the whole table, and `done` reports that the last window has been applied.

Top module: `seg_reseed_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `mem_rd`, `scan_en`, `capture` and `done` are all 0.
- R2: When `start` is seen in the idle or finished state, the seeds are fetched at addresses 0, 1, … `NUM_SEEDS-1` in that order. Each fetch is a single-cycle `mem_rd` pulse. The seed and its step bit are taken from `mem_seed`/`mem_dec` in the following cycle. Fetch 0 starts in the cycle after `start` is sampled.
- R3: The first seed of a pass always applies k = `NUM_SEGS` segments, whatever the value of its step bit.
- R4: For every later seed, a step bit of 1 lowers k by one and a step bit of 0 keeps k unchanged. Once k is 0 it stays 0 and does not wrap.
- R5: Each vector is made of exactly `CHAIN_LEN` consecutive cycles with `scan_en`=1, followed by exactly one cycle with `capture`=1 and `scan_en`=0.
- R6: `scan_out` equals bit 0 of the pattern register. On every shift cycle the register moves right by one bit, and the parity of (state AND `TAPS`) enters bit `SEED_W-1`. The register is loaded from the seed in the cycle after the fetch and is not reloaded between the vectors of a window.
- R7: A seed with k > 0 produces exactly k·`SEG_VECS` vectors. The next fetch, or the finished state, follows in the cycle after that seed's last capture.
- R8: A seed with k = 0 produces no vectors. The next fetch, or the finished state, follows in the cycle right after its load cycle.
- R9: After the last window, `done` rises and stays at 1 with no scan activity until the next `start`. A `start` pulse during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass over the seed table |
| mem_rd | output | 1 | Seed memory read strobe |
| mem_addr | output | ADDR_W | Seed memory address |
| mem_seed | input | SEED_W | Seed word, valid the cycle after `mem_rd` |
| mem_dec | input | 1 | Step bit of the same word (1 = k drops by one) |
| scan_en | output | 1 | Scan shift enable |
| scan_out | output | 1 | Serial scan data |
| capture | output | 1 | One-cycle capture pulse after each vector |
| done | output | 1 | Pass finished |

## Verification
The bench runs three seed tables and compares every cycle against a behavioural model. The first table mixes hold and step bits and sets the step bit on seed 0. This separates a correct first-seed load from one that applies the bit. The second table sets every step bit, so k counts down to zero. This shows whether zero-segment windows are skipped and whether the count saturates instead of wrapping. The third table holds k at full length throughout, which exposes any early cut of a window. A start pulse in the middle of a pass must leave the trace unchanged.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_LOAD,
      ST_SHIFT,
      ST_CAPT,
      ST_DONE
   } rsc_state_e;
endpackage

// File: rtl/rsc_lfsr.sv
module rsc_lfsr #(
   parameter int              SEED_W = 16,
   parameter logic [SEED_W-1:0] TAPS = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SEED_W-1:0] seed,
   input  logic              step,
   output logic              bit_out
);
   logic [SEED_W-1:0] pat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pat_q <= '0;
      else if (load)
         pat_q <= seed;
      else if (step)
         pat_q <= {^(pat_q & TAPS), pat_q[SEED_W-1:1]};
   end

   assign bit_out = pat_q[0];
endmodule

// File: rtl/rsc_modcnt.sv
module rsc_modcnt #(
   parameter int MOD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CW = (MOD > 1) ? $clog2(MOD) : 1;

   generate
      if (MOD == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr)
               cnt_q <= '0;
            else if (inc)
               cnt_q <= (cnt_q == CW'(MOD-1)) ? '0 : cnt_q + 1'b1;
         end
         assign last = (cnt_q == CW'(MOD-1));
      end
   endgenerate
endmodule

// File: rtl/rsc_seg_track.sv
module rsc_seg_track #(
   parameter int NUM_SEGS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seed_ld,
   input  logic first,
   input  logic dec,
   input  logic seg_done,
   output logic k_zero,
   output logic seg_last
);
   localparam int KW = $clog2(NUM_SEGS + 1);

   logic [KW-1:0] load_q;
   logic [KW-1:0] seg_q;
   logic [KW-1:0] k_nxt;

   always_comb begin
      if (first)
         k_nxt = KW'(NUM_SEGS);
      else if (dec && load_q != '0)
         k_nxt = load_q - 1'b1;
      else
         k_nxt = load_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         seg_q  <= '0;
      end else if (seed_ld) begin
         load_q <= k_nxt;
         seg_q  <= k_nxt;
      end else if (seg_done && seg_q != '0) begin
         seg_q  <= seg_q - 1'b1;
      end
   end

   assign k_zero   = (k_nxt == '0);
   assign seg_last = (seg_q == KW'(1));
endmodule

// File: rtl/seg_reseed_ctrl.sv
module seg_reseed_ctrl
   import rsc_pkg::*;
#(
   parameter int              SEED_W    = 16,
   parameter logic [SEED_W-1:0] TAPS    = 16'h002D,
   parameter int              CHAIN_LEN = 8,
   parameter int              SEG_VECS  = 2,
   parameter int              NUM_SEGS  = 4,
   parameter int              NUM_SEEDS = 6,
   parameter int              ADDR_W    = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [SEED_W-1:0] mem_seed,
   input  logic              mem_dec,
   output logic              scan_en,
   output logic              scan_out,
   output logic              capture,
   output logic              done
);
   generate
      if (CHAIN_LEN < 1 || SEG_VECS < 1 || NUM_SEGS < 1 || NUM_SEEDS < 1)
         $error("seg_reseed_ctrl: counts must be at least one");
      if ((2 ** ADDR_W) < NUM_SEEDS)
         $error("seg_reseed_ctrl: ADDR_W too narrow for NUM_SEEDS");
      if (TAPS == '0)
         $error("seg_reseed_ctrl: TAPS must not be zero");
   endgenerate

   rsc_state_e        st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic              first_q;
   logic              bit_last, vec_last, seg_last, k_zero;
   logic              last_seed, seed_ld, shifting, capt, idle_like;

   assign last_seed = (addr_q == ADDR_W'(NUM_SEEDS - 1));
   assign seed_ld   = (st_q == ST_LOAD);
   assign shifting  = (st_q == ST_SHIFT);
   assign capt      = (st_q == ST_CAPT);
   assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE, ST_DONE: if (start) st_d = ST_REQ;
         ST_REQ:           st_d = ST_LOAD;
         ST_LOAD:          st_d = k_zero ? (last_seed ? ST_DONE : ST_REQ) : ST_SHIFT;
         ST_SHIFT:         if (bit_last) st_d = ST_CAPT;
         ST_CAPT: begin
            if (vec_last && seg_last)
               st_d = last_seed ? ST_DONE : ST_REQ;
            else
               st_d = ST_SHIFT;
         end
         default:          st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         first_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (idle_like && start) begin
            addr_q  <= '0;
            first_q <= 1'b1;
         end else begin
            if (seed_ld)
               first_q <= 1'b0;
            if (st_d == ST_REQ)
               addr_q <= addr_q + 1'b1;
         end
      end
   end

   rsc_lfsr #(.SEED_W(SEED_W), .TAPS(TAPS)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(seed_ld), .seed(mem_seed),
      .step(shifting), .bit_out(scan_out));

   rsc_modcnt #(.MOD(CHAIN_LEN)) u_bitcnt (
      .clk(clk), .rst_n(rst_n), .clr(seed_ld), .inc(shifting), .last(bit_last));

   rsc_modcnt #(.MOD(SEG_VECS)) u_veccnt (
      .clk(clk), .rst_n(rst_n), .clr(seed_ld), .inc(capt), .last(vec_last));

   rsc_seg_track #(.NUM_SEGS(NUM_SEGS)) u_segs (
      .clk(clk), .rst_n(rst_n), .seed_ld(seed_ld), .first(first_q),
      .dec(mem_dec), .seg_done(capt && vec_last),
      .k_zero(k_zero), .seg_last(seg_last));

   assign mem_rd   = (st_q == ST_REQ);
   assign mem_addr = addr_q;
   assign scan_en  = shifting;
   assign capture  = capt;
   assign done     = (st_q == ST_DONE);
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
   parameter int CHAIN_LEN = 8,
   parameter int SEG_VECS  = 2,
   parameter int NUM_SEGS  = 4,
   parameter int ADDR_W    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              scan_en,
   input logic              capture,
   input logic              done
);
   localparam int WIN_MAX = NUM_SEGS * SEG_VECS;

   int run_q, win_q, prev_q;
   logic [ADDR_W-1:0] last_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 0;
         win_q  <= 0;
         prev_q <= WIN_MAX;
         last_a <= '0;
      end else begin
         if (capture)      run_q <= 0;
         else if (scan_en) run_q <= run_q + 1;
         if (mem_rd) begin
            win_q  <= 0;
            prev_q <= (mem_addr == '0) ? WIN_MAX : win_q;
            last_a <= mem_addr;
         end else if (capture) begin
            win_q <= win_q + 1;
         end
      end
   end

   AST_SHIFT_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> run_q == CHAIN_LEN); // R5
   AST_CAPT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> $past(scan_en) && !scan_en); // R5
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !scan_en && !capture && !mem_rd); // R9
   AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd && !scan_en && !capture); // R2
   AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr == '0) || (mem_addr == last_a + 1'b1)); // R2
   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> win_q < WIN_MAX); // R7
   AST_WIN_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_addr != '0) |-> win_q <= prev_q); // R4
endmodule

bind seg_reseed_ctrl rsc_checker #(
   .CHAIN_LEN(CHAIN_LEN), .SEG_VECS(SEG_VECS), .NUM_SEGS(NUM_SEGS), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
   .scan_en(scan_en), .capture(capture), .done(done));

// File: tb/seg_reseed_ctrl_test.sv
module seg_reseed_ctrl_test;
   localparam int          SW   = 16;
   localparam logic [15:0] TP   = 16'h002D;
   localparam int          CL   = 8;
   localparam int          SV   = 2;
   localparam int          NS   = 4;
   localparam int          NSD  = 6;
   localparam int          AW   = 3;

   typedef struct {
      bit rd; int a; bit se; bit so; bit so_care; bit cp; bit dn;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic mem_rd, mem_dec, scan_en, scan_out, capture, done;
   logic [AW-1:0] mem_addr;
   logic [SW-1:0] mem_seed;

   logic [SW-1:0] tbl_s [NSD];
   logic          tbl_b [NSD];
   int            win_exp [NSD];
   exp_t          exp_q [$];
   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   seg_reseed_ctrl #(.SEED_W(SW), .TAPS(TP), .CHAIN_LEN(CL), .SEG_VECS(SV),
      .NUM_SEGS(NS), .NUM_SEEDS(NSD), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_seed(mem_seed), .mem_dec(mem_dec),
      .scan_en(scan_en), .scan_out(scan_out), .capture(capture), .done(done));

   always_ff @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd) begin
         mem_seed <= tbl_s[mem_addr];
         mem_dec  <= tbl_b[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic exp_t blank();
      exp_t e;
      e.rd = 0; e.a = 0; e.se = 0; e.so = 0; e.so_care = 0; e.cp = 0; e.dn = 0;
      return e;
   endfunction

   task automatic build();
      int k = 0;
      exp_t e;
      exp_q.delete();
      for (int s = 0; s < NSD; s++) begin
         logic [SW-1:0] st;
         e = blank(); e.rd = 1; e.a = s; exp_q.push_back(e);
         e = blank(); exp_q.push_back(e);
         if (s == 0) k = NS;
         else if (tbl_b[s] && k > 0) k = k - 1;
         win_exp[s] = k * SV;
         st = tbl_s[s];
         for (int v = 0; v < k * SV; v++) begin
            for (int b = 0; b < CL; b++) begin
               e = blank(); e.se = 1; e.so = st[0]; e.so_care = 1;
               exp_q.push_back(e);
               st = {^(st & TP), st[SW-1:1]};
            end
            e = blank(); e.cp = 1; exp_q.push_back(e);
         end
      end
      for (int d = 0; d < 4; d++) begin
         e = blank(); e.dn = 1; exp_q.push_back(e);
      end
   endtask

   function automatic string win_tag(input int idx);
      if (idx == 0) return "R3";
      if (win_exp[idx] == 0) return "R8";
      return "R4 R7";
   endfunction

   task automatic run_pass(input int poke_at);
      int i = 0;
      int caps = 0;
      int widx = -1;
      bit seen_done = 0;
      build();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (exp_q.size() > 0) begin
         exp_t e = exp_q.pop_front();
         chk(mem_rd == e.rd && (!e.rd || int'(mem_addr) == e.a), "R2",
             "fetch rd/addr", {mem_rd, 8'(mem_addr)}, {e.rd, 8'(e.a)});
         chk(scan_en == e.se && capture == e.cp, "R5 R7", "scan_en/capture",
             {scan_en, capture}, {e.se, e.cp});
         if (e.so_care)
            chk(scan_out == e.so, "R6", "scan_out", scan_out, e.so);
         chk(done == e.dn, "R9", "done", done, e.dn);
         if (capture) caps++;
         if (mem_rd || (done && !seen_done)) begin
            if (widx >= 0)
               chk(caps == win_exp[widx], win_tag(widx), "vectors in window",
                   caps, win_exp[widx]);
            widx = int'(mem_addr);
            caps = 0;
            if (done) seen_done = 1;
         end
         start = (i == poke_at);   // R9: start during a pass is ignored
         i++;
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   initial begin
      for (int s = 0; s < NSD; s++) begin
         tbl_s[s] = 16'h0; tbl_b[s] = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk(!mem_rd && !scan_en && !capture && !done, "R1", "outputs in reset",
          {mem_rd, scan_en, capture, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_rd && !scan_en && !capture && !done, "R1", "outputs after reset",
          {mem_rd, scan_en, capture, done}, 0);

      // pass 1: mixed step bits; step bit set on seed 0 (R3)
      tbl_s = '{16'hACE1, 16'h1234, 16'hBEEF, 16'h0F0F, 16'h8001, 16'h5A5A};
      tbl_b = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
      run_pass(25);

      // pass 2: every bit set, count reaches zero and saturates (R4, R8)
      tbl_s = '{16'h7777, 16'hC3C3, 16'h0001, 16'hFFFF, 16'h2468, 16'h9999};
      tbl_b = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
      run_pass(3);

      // pass 3: all hold, full windows throughout (R7)
      tbl_s = '{16'h1111, 16'h2222, 16'h4444, 16'h8888, 16'hF00D, 16'hD00F};
      tbl_b = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      run_pass(200);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cyc > 50000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule